// File: doc/BRIEF.md
# SPI EEPROM Page Command Sequencer

This block is an SPI master that carries out complete page transactions on a serial EEPROM organised in 256-byte pages. A host asks for one of two operations, a page read or a page write, and gives a 16-bit page number with it. The block then produces every chip-select frame the memory needs. It generates the serial clock and shifts opcodes, address bytes and data. On writes it also clears any write protection and waits for the internal write cycle to finish. Page data passes through a byte-wide port, with a valid/ready handshake in each direction.

A read is a single frame: the read opcode, the page address and then the page data. A write is a chain of frames. The block first reads the status register. If protection is active it clears it with a status write. It then sends a write-enable in its own frame, followed by the write frame with the page data. Status reads are repeated until the memory reports that it is idle. The block holds every chip-select edge apart from the surrounding activity by a guard time. A byte counts as finished only once its eighth bit has been received.

Top module: `spi_page_seq`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, busy and done are 0, wr_ready is 0 and rd_valid is 0.
- R2: A page read (write_mode 0) uses exactly one frame. The frame carries opcode 0x03, the page high byte, the page low byte, 0x00 and then PAGE_BYTES data bytes. The data bytes appear on rd_data in order.
- R3: Bits go out most significant first. sclk idles at 0, MISO is captured on the rising edge of sclk, and MOSI changes only while sclk is 0.
- R4: Whenever the block is only receiving, it sends 0xFF on MOSI. This covers the data bytes of a read and the second byte of every status read.
- R5: A page write (write_mode 1) on an unprotected memory sends these frames in order: a status read (0x05 plus one byte), a write-enable (0x06 alone), and a write frame (0x02, page high, page low, 0x00, then PAGE_BYTES bytes taken from wr_data in order).
- R6: A status value with any of bits 7, 3 or 2 set causes a status-write frame (0x01 plus one byte) between the first status read and the write-enable. That byte is the status read back with those three bits cleared.
- R7: After the write frame, status-read frames repeat until one of them returns bit 0 as 0.
- R8: cs_n falls exactly GUARD cycles after busy rises. Between two frames of one operation, cs_n stays high for exactly 2*GUARD cycles. done rises exactly GUARD cycles after the final rise of cs_n.
- R9: cs_n rises only with sclk low and the byte in flight fully received, so every frame holds a whole number of bytes. sclk never pulses while cs_n is high.
- R10: busy is 1 from the cycle after start is accepted until the operation ends. done is a single-cycle pulse that occurs with busy at 0. A start that arrives while busy is 1 has no effect.
- R11: wr_ready is raised only while the write frame waits for a data byte. While wr_valid (during a write) or rd_ready (during a read) is held at 0, the sequencer stalls with sclk at 0 and keeps its pending handshake raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe, accepted only when idle |
| write_mode | input | 1 | 1 selects a page write, 0 a page read |
| page | input | 16 | Page number of the request |
| wr_data | input | 8 | Byte to be written |
| wr_valid | input | 1 | wr_data holds a valid byte |
| wr_ready | output | 1 | Sequencer takes wr_data at this edge if valid |
| rd_data | output | 8 | Byte read from the page |
| rd_valid | output | 1 | rd_data holds a byte |
| rd_ready | input | 1 | Host accepts rd_data |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the memory |
| miso | input | 1 | Serial data from the memory |
| cs_n | output | 1 | Active-low chip select |

## Verification
The chip select falls GUARD cycles after busy rises, and the gap between frames is exactly 2*GUARD cycles. done follows the final chip-select release by GUARD cycles. A read byte reaches rd_valid on the clock after its eighth falling sclk edge. The bench watches these intervals with posedge monitors that count cycles from the preceding event and compare the count with the exact expected value. It checks outputs at falling clock edges, and only after the done pulse for anything that depends on a whole operation. Frame contents are decoded by a behavioural memory model on the sclk edges, so both order and length of every frame are compared with the sequence the requirements predict.

// File: rtl/spi_seq_pkg.sv
// Package: opcodes, status-register bit positions and the state types
// shared by the page sequencer modules.
package spi_seq_pkg;

    localparam logic [7:0] OPC_READ  = 8'h03;
    localparam logic [7:0] OPC_WRITE = 8'h02;
    localparam logic [7:0] OPC_WREN  = 8'h06;
    localparam logic [7:0] OPC_RDSR  = 8'h05;
    localparam logic [7:0] OPC_WRSR  = 8'h01;

    // Status register: bit 0 busy-writing, bits 2/3 block protect, bit 7 protect enable
    localparam int         SR_BUSY_BIT  = 0;
    localparam logic [7:0] SR_PROT_MASK = 8'h8C;

    localparam int HDR_BYTES = 4;   // opcode + three address bytes
    localparam int PAGE_W    = 16;  // page number width
    localparam logic [7:0] FILL_BYTE = 8'hFF;

    typedef enum logic [2:0] {
        FR_READ, FR_RDSR, FR_WRSR, FR_WREN, FR_WRITE, FR_POLL
    } frame_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_OPEN, ST_LAUNCH, ST_WAIT, ST_DELIVER, ST_CLOSE
    } state_e;

    // Opcode that leads each frame kind
    function automatic logic [7:0] frame_opcode(frame_e f);
        case (f)
            FR_READ:  return OPC_READ;
            FR_WRITE: return OPC_WRITE;
            FR_WREN:  return OPC_WREN;
            FR_WRSR:  return OPC_WRSR;
            default:  return OPC_RDSR;
        endcase
    endfunction

endpackage

// File: rtl/spi_byte_engine.sv
// Module: spi_byte_engine
// Shifts one byte out and one byte in, MSB first, with sclk idle low and
// data captured on the rising edge (first edge of each bit). sclk half
// period is HALF_DIV system clocks. fin pulses for one cycle after the
// eighth falling edge, i.e. only once the received byte is complete.
// Assumes go is only raised while busy is 0.
module spi_byte_engine #(
    parameter int HALF_DIV = 42
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic [7:0] rx_byte,
    output logic       fin,
    output logic       busy
);
    localparam int DW = $clog2(HALF_DIV + 1);

    logic [DW-1:0] divc;
    logic [2:0]    bitc;
    logic [7:0]    txs;
    logic [7:0]    rxs;

    // Divider, edge generation and both shift registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            sclk <= 1'b0;
            divc <= '0;
            bitc <= '0;
            txs  <= '0;
            rxs  <= '0;
            fin  <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (!busy) begin
                if (go) begin
                    busy <= 1'b1;
                    txs  <= tx_byte;
                    divc <= '0;
                    bitc <= '0;
                    sclk <= 1'b0;
                end
            end else if (divc == DW'(HALF_DIV - 1)) begin
                divc <= '0;
                if (!sclk) begin
                    sclk <= 1'b1;
                    rxs  <= {rxs[6:0], miso};
                end else begin
                    sclk <= 1'b0;
                    if (bitc == 3'd7) begin
                        busy <= 1'b0;
                        fin  <= 1'b1;
                    end else begin
                        bitc <= bitc + 3'd1;
                        txs  <= {txs[6:0], 1'b0};
                    end
                end
            end else begin
                divc <= divc + DW'(1);
            end
        end
    end

    assign mosi    = txs[7];
    assign rx_byte = rxs;

    // R3: MOSI may only move while sclk is low
    p_mosi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(mosi));

    // R9: a byte completes only right after a falling sclk edge
    p_fin_after_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> (!sclk && $past(sclk)));

endmodule

// File: rtl/spi_seq_ctrl.sv
// Module: spi_seq_ctrl
// Frame-level sequencer. Opens and closes chip-select frames with GUARD
// cycles on each side of every cs_n edge, feeds the byte engine with
// opcode, address, fill or write-data bytes, returns read data and
// chains the frames of a page write (status read, optional protection
// clear, write enable, write, busy polling). Assumes a 16-bit page
// number and one memory on the bus.
module spi_seq_ctrl
    import spi_seq_pkg::*;
#(
    parameter int PAGE_BYTES = 256,
    parameter int GUARD      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              write_mode,
    input  logic [PAGE_W-1:0] page,
    input  logic [7:0]        wr_data,
    input  logic              wr_valid,
    output logic              wr_ready,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic              eng_go,
    output logic [7:0]        eng_tx,
    input  logic              eng_fin,
    input  logic [7:0]        eng_rx,
    input  logic              eng_busy,
    input  logic              sclk,
    output logic              cs_n,
    output logic              busy,
    output logic              done
);
    localparam int LEN_BIG = PAGE_BYTES + HDR_BYTES;
    localparam int IW      = $clog2(LEN_BIG);
    localparam int GW      = $clog2(GUARD + 1);

    state_e            st;
    frame_e            fr;
    frame_e            fr_next;
    logic              op_end;
    logic              op_wr;
    logic [PAGE_W-1:0] pg;
    logic [IW-1:0]     idx;
    logic [IW-1:0]     last_idx;
    logic [GW-1:0]     gcnt;
    logic              gph;
    logic [7:0]        stat;
    logic [7:0]        rdq;
    logic              in_data;
    logic              need_wr;
    logic              at_last;
    logic              guard_end;

    // Index of the final byte of the current frame
    always_comb begin
        case (fr)
            FR_WREN:                   last_idx = '0;
            FR_RDSR, FR_POLL, FR_WRSR: last_idx = IW'(1);
            default:                   last_idx = IW'(LEN_BIG - 1);
        endcase
    end

    assign in_data   = (idx >= IW'(HDR_BYTES));
    assign need_wr   = (fr == FR_WRITE) && in_data;
    assign at_last   = (idx == last_idx);
    assign guard_end = (gcnt == GW'(GUARD - 1));

    // Byte to shift next: opcode, address, cleared status, data or fill
    always_comb begin
        eng_tx = FILL_BYTE;
        if (idx == '0) begin
            eng_tx = frame_opcode(fr);
        end else if (fr == FR_WRSR) begin
            eng_tx = stat & ~SR_PROT_MASK;
        end else if (fr == FR_READ || fr == FR_WRITE) begin
            case (idx)
                IW'(1):  eng_tx = pg[PAGE_W-1 -: 8];
                IW'(2):  eng_tx = pg[7:0];
                IW'(3):  eng_tx = 8'h00;
                default: eng_tx = (fr == FR_WRITE) ? wr_data : FILL_BYTE;
            endcase
        end
    end

    // Frame that follows the current one, or end of operation
    always_comb begin
        fr_next = fr;
        op_end  = 1'b0;
        case (fr)
            FR_RDSR:  fr_next = ((stat & SR_PROT_MASK) != 8'h00) ? FR_WRSR : FR_WREN;
            FR_WRSR:  fr_next = FR_WREN;
            FR_WREN:  fr_next = FR_WRITE;
            FR_WRITE: fr_next = FR_POLL;
            FR_POLL:  op_end  = !stat[SR_BUSY_BIT];
            default:  op_end  = 1'b1;
        endcase
    end

    assign wr_ready = (st == ST_LAUNCH) && need_wr;
    assign eng_go   = (st == ST_LAUNCH) && (!need_wr || wr_valid);
    assign rd_valid = (st == ST_DELIVER);
    assign rd_data  = rdq;
    assign busy     = (st != ST_IDLE);

    // Main sequencer: guards, byte stepping, status capture, frame chaining
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            fr    <= FR_READ;
            op_wr <= 1'b0;
            pg    <= '0;
            idx   <= '0;
            gcnt  <= '0;
            gph   <= 1'b0;
            stat  <= '0;
            rdq   <= '0;
            cs_n  <= 1'b1;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        op_wr <= write_mode;
                        pg    <= page;
                        fr    <= write_mode ? FR_RDSR : FR_READ;
                        gcnt  <= '0;
                        gph   <= 1'b0;
                        st    <= ST_OPEN;
                    end
                end
                ST_OPEN: begin
                    if (!guard_end) begin
                        gcnt <= gcnt + GW'(1);
                    end else begin
                        gcnt <= '0;
                        if (!gph) begin
                            cs_n <= 1'b0;
                            gph  <= 1'b1;
                        end else begin
                            gph <= 1'b0;
                            idx <= '0;
                            st  <= ST_LAUNCH;
                        end
                    end
                end
                ST_LAUNCH: begin
                    if (eng_go) st <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (eng_fin) begin
                        if ((fr == FR_RDSR || fr == FR_POLL) && idx == IW'(1))
                            stat <= eng_rx;
                        if (fr == FR_READ && in_data) begin
                            rdq <= eng_rx;
                            st  <= ST_DELIVER;
                        end else if (at_last) begin
                            gcnt <= '0;
                            gph  <= 1'b0;
                            st   <= ST_CLOSE;
                        end else begin
                            idx <= idx + IW'(1);
                            st  <= ST_LAUNCH;
                        end
                    end
                end
                ST_DELIVER: begin
                    if (rd_ready) begin
                        if (at_last) begin
                            gcnt <= '0;
                            gph  <= 1'b0;
                            st   <= ST_CLOSE;
                        end else begin
                            idx <= idx + IW'(1);
                            st  <= ST_LAUNCH;
                        end
                    end
                end
                ST_CLOSE: begin
                    if (!guard_end) begin
                        gcnt <= gcnt + GW'(1);
                    end else begin
                        gcnt <= '0;
                        if (!gph) begin
                            cs_n <= 1'b1;
                            gph  <= 1'b1;
                        end else begin
                            gph <= 1'b0;
                            if (op_end) begin
                                done <= 1'b1;
                                st   <= ST_IDLE;
                            end else begin
                                fr <= fr_next;
                                st <= ST_OPEN;
                            end
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R9: the serial clock only runs inside a frame
    p_sclk_in_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n);

    // R9: release of chip select only with the engine idle and sclk low
    p_clean_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> (!eng_busy && !sclk));

    // R10: done lasts one cycle
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: done arrives with busy low and chip select released
    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && cs_n));

    // R10: a start while busy leaves the captured page untouched
    p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(pg));

    // R11: write data is only requested inside a write operation's frame
    p_wr_ready_scope_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> (op_wr && !cs_n && !eng_busy));

    // R11: while read data waits for the host, no bits are clocked
    p_hold_no_clock_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (!eng_busy && !sclk));

endmodule

// File: rtl/spi_page_seq.sv
// Module: spi_page_seq (top)
// SPI master that performs whole-page reads and writes on a serial
// EEPROM with PAGE_BYTES-byte pages. HALF_DIV sets the sclk half period
// in system clocks (42 gives about 3 MHz from 250 MHz); GUARD sets the
// hold-off in cycles on both sides of every chip-select edge.
module spi_page_seq
    import spi_seq_pkg::*;
#(
    parameter int HALF_DIV   = 42,
    parameter int GUARD      = 3,
    parameter int PAGE_BYTES = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              write_mode,
    input  logic [PAGE_W-1:0] page,
    input  logic [7:0]        wr_data,
    input  logic              wr_valid,
    output logic              wr_ready,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic              busy,
    output logic              done,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n
);
    logic       eng_go;
    logic [7:0] eng_tx;
    logic       eng_fin;
    logic [7:0] eng_rx;
    logic       eng_busy;

    spi_seq_ctrl #(
        .PAGE_BYTES (PAGE_BYTES),
        .GUARD      (GUARD)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .write_mode (write_mode),
        .page       (page),
        .wr_data    (wr_data),
        .wr_valid   (wr_valid),
        .wr_ready   (wr_ready),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .rd_ready   (rd_ready),
        .eng_go     (eng_go),
        .eng_tx     (eng_tx),
        .eng_fin    (eng_fin),
        .eng_rx     (eng_rx),
        .eng_busy   (eng_busy),
        .sclk       (sclk),
        .cs_n       (cs_n),
        .busy       (busy),
        .done       (done)
    );

    spi_byte_engine #(
        .HALF_DIV (HALF_DIV)
    ) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (eng_go),
        .tx_byte (eng_tx),
        .miso    (miso),
        .sclk    (sclk),
        .mosi    (mosi),
        .rx_byte (eng_rx),
        .fin     (eng_fin),
        .busy    (eng_busy)
    );

endmodule

// File: tb/spi_page_seq_test.sv
// Bench for spi_page_seq: vector table of operations, then directed
// tests for reset, ignored starts and handshake stalls. A behavioural
// EEPROM model decodes frames on the sclk edges.
module spi_page_seq_test;
    localparam int HALF = 2;
    localparam int G    = 3;
    localparam int PB   = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        write_mode = 1'b0;
    logic [15:0] page = '0;
    logic [7:0]  wr_data;
    logic        wr_valid = 1'b1;
    logic        wr_ready;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic        rd_ready = 1'b1;
    logic        busy, done, sclk, mosi, cs_n;
    logic        miso = 1'b0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    spi_page_seq #(.HALF_DIV(HALF), .GUARD(G), .PAGE_BYTES(PB)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .write_mode(write_mode),
        .page(page), .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .busy(busy), .done(done), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    function automatic logic [7:0] mpat(logic [15:0] p, int i);
        return (8'(i) ^ p[7:0]) + p[15:8];
    endfunction
    function automatic logic [7:0] wpat(logic [15:0] p, int i);
        return 8'(i * 5) ^ p[15:8] ^ p[7:0] ^ 8'h96;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    logic [7:0]  cfg_stat = 8'h00;
    int          cfg_polls = 0;
    int          wip_left = 0;
    logic        prev_cs = 1'b1, prev_sclk = 1'b0;
    int          bitcnt = 0, nbyte = 0;
    logic [7:0]  shin = '0, opc = '0, hdr1 = '0, hdr2 = '0, hdr3 = '0;
    logic [7:0]  wbuf [PB];
    logic [7:0]  fr_op [64];
    int          fr_len [64];
    logic [7:0]  fr_a1 [64], fr_a2 [64], fr_a3 [64];
    int          nfr = 0;
    int          nonff = 0;
    int          partial_bad = 0;

    function automatic logic [7:0] out_byte(int n);
        if (n == 0) return 8'h00;
        if (opc == 8'h05) return {cfg_stat[7:1], wip_left > 0};
        if (opc == 8'h03 && n >= 4) return mpat({hdr1, hdr2}, n - 4);
        return 8'h00;
    endfunction

    always @(cs_n or sclk) begin
        if (prev_cs === 1'b1 && cs_n === 1'b0) begin
            bitcnt = 0; nbyte = 0; opc = 8'h00; miso = 1'b0;
        end else if (prev_cs === 1'b0 && cs_n === 1'b1) begin
            if (bitcnt % 8 != 0) partial_bad++;
            fr_op[nfr % 64] = opc;  fr_len[nfr % 64] = nbyte;
            fr_a1[nfr % 64] = hdr1; fr_a2[nfr % 64] = hdr2; fr_a3[nfr % 64] = hdr3;
            nfr++;
            if (opc == 8'h02) wip_left = cfg_polls;
            else if (opc == 8'h05 && wip_left > 0) wip_left--;
        end
        if (cs_n === 1'b0 && sclk === 1'b1 && prev_sclk === 1'b0) begin
            shin = {shin[6:0], mosi};
            bitcnt++;
            if (bitcnt % 8 == 0) begin
                if (nbyte == 0) opc = shin;
                else if (nbyte == 1) hdr1 = shin;
                else if (nbyte == 2) hdr2 = shin;
                else if (nbyte == 3) hdr3 = shin;
                if (opc == 8'h05 && nbyte == 1 && shin != 8'hFF) nonff++;
                if (opc == 8'h03 && nbyte >= 4 && shin != 8'hFF) nonff++;
                if (opc == 8'h02 && nbyte >= 4 && nbyte - 4 < PB) wbuf[nbyte - 4] = shin;
                nbyte++;
            end
        end
        if (cs_n === 1'b0 && sclk === 1'b0 && prev_sclk === 1'b1) begin
            logic [7:0] ob;
            ob = out_byte(bitcnt / 8);
            miso = ob[7 - (bitcnt % 8)];
        end
        prev_cs = cs_n;
        prev_sclk = sclk;
    end

    // ---------------- clock-domain monitors ----------------
    logic [15:0] cur_page = '0;
    int rd_idx = 0, rd_err = 0, wr_idx = 0;
    int done_cnt = 0, done_lat_bad = 0, since_rise = 0;
    int gap_run = 0, gap_bad = 0, sclk_rises = 0;
    logic gap_first = 1'b1, cs_q = 1'b1, sclk_q = 1'b0;

    assign wr_data = wpat(cur_page, wr_idx);

    always @(posedge clk) begin
        cs_q   <= cs_n;
        sclk_q <= sclk;
        if (sclk && !sclk_q) sclk_rises <= sclk_rises + 1;
        if (start && !busy) begin
            rd_idx <= 0;
            wr_idx <= 0;
        end else begin
            if (rd_valid && rd_ready) begin
                if (rd_data != mpat(cur_page, rd_idx)) rd_err <= rd_err + 1;
                rd_idx <= rd_idx + 1;
            end
            if (wr_valid && wr_ready) wr_idx <= wr_idx + 1;
        end
        if (cs_n && !cs_q) since_rise <= 1;
        else if (since_rise < 1000000) since_rise <= since_rise + 1;
        if (done) begin
            done_cnt <= done_cnt + 1;
            if (since_rise != G) done_lat_bad <= done_lat_bad + 1;   // R8
        end
        if (!busy) begin
            gap_run <= 0;
            gap_first <= 1'b1;
        end else if (cs_n) begin
            gap_run <= gap_run + 1;
        end else if (cs_q) begin
            if (gap_run != (gap_first ? G : 2 * G)) gap_bad <= gap_bad + 1;  // R8
            gap_first <= 1'b0;
            gap_run <= 0;
        end
    end

    // ---------------- operation runner ----------------
    task automatic wait_done(input int d0);
        while (done_cnt == d0) @(negedge clk);
    endtask

    task automatic run_op(input bit w, input logic [15:0] p,
                          input logic [7:0] st, input int polls);
        int base, d0, ne, bad, dix, npoll;
        logic [7:0] eo [16];
        int el [16];
        cfg_stat = st; cfg_polls = polls; cur_page = p;
        base = nfr; d0 = done_cnt;
        ne = 0;
        if (!w) begin
            eo[0] = 8'h03; el[0] = PB + 4; ne = 1; dix = 0;
        end else begin
            eo[ne] = 8'h05; el[ne] = 2; ne++;
            if ((st & 8'h8C) != 0) begin eo[ne] = 8'h01; el[ne] = 2; ne++; end
            eo[ne] = 8'h06; el[ne] = 1; ne++;
            dix = ne;
            eo[ne] = 8'h02; el[ne] = PB + 4; ne++;
            for (int k = 0; k <= polls; k++) begin eo[ne] = 8'h05; el[ne] = 2; ne++; end
        end
        @(negedge clk);
        start = 1'b1; write_mode = w; page = p;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R10", "busy after accept", int'(busy), 1);
        wait_done(d0);
        repeat (4) @(negedge clk);
        chk(nfr - base == ne, w ? "R7" : "R2", "frame count", nfr - base, ne);
        bad = 0; npoll = 0;
        for (int k = 0; k < ne && k < nfr - base; k++) begin
            if (fr_op[(base + k) % 64] != eo[k] || fr_len[(base + k) % 64] != el[k]) bad++;
            if (k > dix && fr_op[(base + k) % 64] == 8'h05) npoll++;
        end
        chk(bad == 0, w ? "R5" : "R2", "frame opcode/length mismatches", bad, 0);
        chk(fr_a1[(base + dix) % 64] == p[15:8] && fr_a2[(base + dix) % 64] == p[7:0]
            && fr_a3[(base + dix) % 64] == 8'h00, w ? "R5" : "R2", "address bytes",
            int'({fr_a1[(base + dix) % 64], fr_a2[(base + dix) % 64]}), int'(p));
        if (!w) begin
            chk(rd_idx == PB, "R2", "bytes delivered", rd_idx, PB);
            chk(rd_err == 0, "R3", "read data mismatches", rd_err, 0);
            chk(wr_idx == 0, "R11", "write bytes taken during read", wr_idx, 0);
        end else begin
            bad = 0;
            for (int i = 0; i < PB; i++) if (wbuf[i] != wpat(p, i)) bad++;
            chk(bad == 0, "R3", "written data mismatches", bad, 0);
            chk(npoll == polls + 1, "R7", "status polls", npoll, polls + 1);
            if ((st & 8'h8C) != 0)
                chk(fr_a1[(base + 1) % 64] == (st & 8'h73), "R6", "status clear value",
                    int'(fr_a1[(base + 1) % 64]), int'(st & 8'h73));
        end
        chk(nonff == 0, "R4", "non-fill bytes while receiving", nonff, 0);
        chk(gap_bad == 0 && done_lat_bad == 0, "R8", "guard timing faults",
            gap_bad + done_lat_bad, 0);
        chk(partial_bad == 0, "R9", "frames with partial bytes", partial_bad, 0);
        chk(done_cnt - d0 == 1 && !busy, "R10", "done pulses", done_cnt - d0, 1);
    endtask

    // write(1) page(16) status(8) polls(8)
    localparam logic [32:0] VEC [5] = '{
        {1'b0, 16'h1234, 8'h00, 8'd0},
        {1'b1, 16'hABCD, 8'h00, 8'd2},
        {1'b1, 16'h0102, 8'h8C, 8'd0},
        {1'b1, 16'h7F00, 8'h04, 8'd1},
        {1'b0, 16'hFFFF, 8'h00, 8'd0}
    };

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int rises, d0, base;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(cs_n && !sclk && !busy && !done && !wr_ready && !rd_valid, "R1",
            "reset outputs", int'({cs_n, sclk, busy, done, wr_ready, rd_valid}), 32);

        foreach (VEC[i]) run_op(VEC[i][32], VEC[i][31:16], VEC[i][15:8], int'(VEC[i][7:0]));

        // R10: start while busy is ignored
        base = nfr; d0 = done_cnt; cur_page = 16'h0F0F;
        @(negedge clk); start = 1'b1; write_mode = 1'b0; page = 16'h0F0F;
        @(negedge clk); start = 1'b0;
        repeat (50) @(negedge clk);
        start = 1'b1; write_mode = 1'b1; page = 16'h5555;
        @(negedge clk); start = 1'b0;
        wait_done(d0);
        repeat (200) @(negedge clk);
        chk(nfr - base == 1 && fr_op[base % 64] == 8'h03, "R10", "frames after ignored start",
            nfr - base, 1);
        chk(fr_a1[base % 64] == 8'h0F && !busy && done_cnt - d0 == 1, "R10",
            "page of ignored start", int'(fr_a1[base % 64]), 15);

        // R11: read stall while rd_ready low
        d0 = done_cnt; cur_page = 16'h2222; rd_ready = 1'b0;
        @(negedge clk); start = 1'b1; write_mode = 1'b0; page = 16'h2222;
        @(negedge clk); start = 1'b0;
        while (!rd_valid) @(negedge clk);
        rises = sclk_rises;
        repeat (300) @(negedge clk);
        chk(sclk_rises == rises && rd_valid && !sclk, "R11", "clocks during read stall",
            sclk_rises - rises, 0);
        chk(rd_data == mpat(16'h2222, 0), "R11", "held read byte", int'(rd_data),
            int'(mpat(16'h2222, 0)));
        rd_ready = 1'b1;
        wait_done(d0);
        @(negedge clk);
        chk(rd_idx == PB && rd_err == 0, "R11", "read after stall", rd_idx, PB);

        // R11: write stall while wr_valid low
        d0 = done_cnt; cur_page = 16'h3344; cfg_stat = 8'h00; cfg_polls = 0; wr_valid = 1'b0;
        @(negedge clk); start = 1'b1; write_mode = 1'b1; page = 16'h3344;
        @(negedge clk); start = 1'b0;
        while (!wr_ready) @(negedge clk);
        rises = sclk_rises;
        repeat (300) @(negedge clk);
        chk(sclk_rises == rises && wr_ready && !cs_n, "R11", "clocks during write stall",
            sclk_rises - rises, 0);
        wr_valid = 1'b1;
        wait_done(d0);
        @(negedge clk);
        begin
            int bad;
            bad = 0;
            for (int i = 0; i < PB; i++) if (wbuf[i] != wpat(16'h3344, i)) bad++;
            chk(bad == 0 && wr_idx == PB, "R11", "write data after stall", bad, 0);
        end
        finish_run();
    end

endmodule